// File: doc/BRIEF.md
# NAND Bus Command Decoder

This block is the device-side front end of a page-organised NAND flash. It watches an 8-bit multiplexed bus together with the chip-select, command-latch, address-latch, read-strobe, write-strobe and write-protect pins, all sampled on the system clock. It sorts each write-strobe rising edge into a command, address or data cycle. It builds the column and row fields from up to five address cycles and walks the two-step command sequences. It also drives an active-low ready flag. Array operations are modelled as fixed clock-count delays.

A column pointer follows the sequential data stream. Each accepted data-in byte is presented on a write strobe for the page buffer and then advances the pointer. Each read-strobe falling edge also advances it. A random-output sequence moves the pointer to a new column inside the page that is already loaded. When a read, program or erase is confirmed, the block raises a one-cycle start pulse with the operation kind and the page and block indices.

Top module: `nand_cmd_if`

## Requirements
- R1: After reset, rb_n is 1, col_ptr is 0, op_go and din_we are 0, and the block is in read mode.
- R2: A bus cycle is taken only on a write-strobe rising edge with ce_n low and re_n high. cle=1/ale=0 marks a command, ale=1/cle=0 an address, and both low a data byte. Address byte 0 is column bits 7:0 and byte 1 bits 3:0 are column bits 11:8. Bytes 2, 3 and 4 form row bits 7:0, 15:8 and 23:16. page_idx is row[5:0] and block_idx is row[17:6]. Address cycles after the fifth are ignored.
- R3: After 80h and its address, each data cycle pulses din_we with the byte on din_data, and col_ptr then steps by one.
- R4: A read-strobe falling edge while ready advances col_ptr by one. col_ptr never exceeds 2111 (page of 2048 main plus 64 spare bytes). A loaded column above 2111 becomes 2111.
- R5: 00h, address, 30h pulses op_go with op_kind=1 (read). While read mode holds, a lone 30h repeats the read with the stored row.
- R6: 05h, two column cycles, E0h loads col_ptr with no array operation. This sequence is refused while a cache read is active. A cache read is started by 00h, address, 31h (op_kind=1) and is ended by 34h.
- R7: 80h, address, data, 10h starts a program (op_kind=2). 60h, three row cycles, D0h starts an erase (op_kind=3). If wp_n is low at the opening code or at the confirm, the sequence is refused.
- R8: rb_n goes low with op_go and stays low for exactly 20, 40 or 60 clocks for read, program or erase.
- R9: While rb_n is low, all command, address, data and read-strobe cycles are ignored.
- R10: An unrecognised command byte drops any pending sequence, so a later confirm starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_n | input | 1 | Chip select, active low |
| cle | input | 1 | Command latch qualifier |
| ale | input | 1 | Address latch qualifier |
| re_n | input | 1 | Read strobe, active low |
| we_n | input | 1 | Write strobe, cycle taken on rising edge |
| wp_n | input | 1 | Write protect level, active low |
| io_in | input | 8 | Multiplexed command/address/data byte |
| rb_n | output | 1 | Ready (1) / busy (0) |
| col_ptr | output | 12 | Current column pointer |
| page_idx | output | 6 | Page within block from row address |
| block_idx | output | 12 | Block index from row address |
| din_we | output | 1 | Data-in byte strobe to page buffer |
| din_data | output | 8 | Data-in byte |
| op_go | output | 1 | One-cycle start of an array operation |
| op_kind | output | 2 | 1 read, 2 program, 3 erase |

## Verification
A wrong sequence state shows up at the next confirm code. Either op_go fires when it should not, or it stays silent, or it carries the wrong kind, and the scoreboard catches each case in the cycle the pulse is due. An address slot counter that is off by one puts a byte into the wrong field. That shows as a wrong page or block index on the very next start pulse, or as a wrong col_ptr two clocks after the second column cycle. A busy timer that is off by one clock is caught by sampling rb_n on both sides of the expected release edge.

// File: rtl/nand_ci_pkg.sv
package nand_ci_pkg;

   typedef enum logic [1:0] {
      OP_NONE  = 2'd0,
      OP_READ  = 2'd1,
      OP_PROG  = 2'd2,
      OP_ERASE = 2'd3
   } op_kind_e;

   typedef enum logic [2:0] {
      S_IDLE,
      S_RD_ADR,
      S_RDO_ADR,
      S_PG,
      S_ER_ADR
   } seq_e;

   localparam logic [7:0] C_READ      = 8'h00;
   localparam logic [7:0] C_READ_GO   = 8'h30;
   localparam logic [7:0] C_CACHE_GO  = 8'h31;
   localparam logic [7:0] C_CACHE_END = 8'h34;
   localparam logic [7:0] C_RDO       = 8'h05;
   localparam logic [7:0] C_RDO_GO    = 8'hE0;
   localparam logic [7:0] C_PROG      = 8'h80;
   localparam logic [7:0] C_PROG_GO   = 8'h10;
   localparam logic [7:0] C_ERASE     = 8'h60;
   localparam logic [7:0] C_ERASE_GO  = 8'hD0;

   localparam int ADDR_CYCLES = 5;
   localparam int ROW_FIRST   = 2;

endpackage

// File: rtl/nand_ci_bus_sampler.sv
module nand_ci_bus_sampler (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ce_n,
   input  logic       cle,
   input  logic       ale,
   input  logic       re_n,
   input  logic       we_n,
   input  logic [7:0] io_in,
   output logic       cmd_ev,
   output logic       adr_ev,
   output logic       dat_ev,
   output logic       re_ev,
   output logic [7:0] ev_byte
);
   logic we_q, re_q;
   logic we_rise, re_fall, sel;

   assign we_rise = !we_q && we_n;
   assign re_fall = re_q && !re_n;
   assign sel     = we_rise && !ce_n && re_n;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         we_q    <= 1'b1;
         re_q    <= 1'b1;
         cmd_ev  <= 1'b0;
         adr_ev  <= 1'b0;
         dat_ev  <= 1'b0;
         re_ev   <= 1'b0;
         ev_byte <= '0;
      end else begin
         we_q    <= we_n;
         re_q    <= re_n;
         cmd_ev  <= sel && cle && !ale;
         adr_ev  <= sel && ale && !cle;
         dat_ev  <= sel && !cle && !ale;
         re_ev   <= re_fall && !ce_n && we_n && !cle && !ale;
         ev_byte <= io_in;
      end
   end
endmodule

// File: rtl/nand_ci_addr_asm.sv
module nand_ci_addr_asm
   import nand_ci_pkg::*;
#(
   parameter int COL_W    = 12,
   parameter int PAGE_W   = 6,
   parameter int BLK_W    = 12,
   parameter int LAST_COL = 2111
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_ev,
   input  logic              adr_ev,
   input  logic              col_inc,
   input  logic [7:0]        ev_byte,
   output logic [COL_W-1:0]  col_ptr,
   output logic [PAGE_W-1:0] page_idx,
   output logic [BLK_W-1:0]  block_idx
);
   localparam int ROW_W = 8 * (ADDR_CYCLES - ROW_FIRST);
   localparam logic [COL_W-1:0] LAST = COL_W'(LAST_COL);

   if (COL_W < 9 || COL_W > 16) begin : g_bad_col
      $error("column width must lie between 9 and 16 bits");
   end
   if (PAGE_W + BLK_W > ROW_W - 1) begin : g_bad_row
      $error("page and block fields exceed the row address bytes");
   end

   logic [2:0]       slot;
   logic [7:0]       col_lo;
   logic [ROW_W-1:0] row;
   logic [COL_W-1:0] col_raw;
   logic             unused_row;

   for (genvar k = 0; k < ADDR_CYCLES - ROW_FIRST; k++) begin : g_row_byte
      logic [7:0] q;
      always_ff @(posedge clk) begin
         if (!rst_n)
            q <= '0;
         else if (adr_ev && slot == 3'(k + ROW_FIRST))
            q <= ev_byte;
      end
      assign row[8*k +: 8] = q;
   end

   assign col_raw    = {ev_byte[COL_W-9:0], col_lo};
   assign page_idx   = row[PAGE_W-1:0];
   assign block_idx  = row[PAGE_W+BLK_W-1:PAGE_W];
   assign unused_row = ^row[ROW_W-1:PAGE_W+BLK_W];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         slot    <= '0;
         col_lo  <= '0;
         col_ptr <= '0;
      end else begin
         if (cmd_ev)
            slot <= (ev_byte == C_ERASE) ? 3'(ROW_FIRST) : 3'd0;
         else if (adr_ev && slot < 3'(ADDR_CYCLES))
            slot <= slot + 3'd1;

         if (adr_ev && slot == 3'd0)
            col_lo <= ev_byte;

         if (adr_ev && slot == 3'd1)
            col_ptr <= (col_raw > LAST) ? LAST : col_raw;
         else if (col_inc && col_ptr != LAST)
            col_ptr <= col_ptr + COL_W'(1);
      end
   end

   // R4: pointer stays inside the page
   a_r4_col_bound: assert property (@(posedge clk) disable iff (!rst_n)
      col_ptr <= LAST);

   // R2: address cycles beyond the fifth leave the row untouched
   a_r2_extra_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      adr_ev && slot == 3'(ADDR_CYCLES) |=> $stable(page_idx) && $stable(block_idx));
endmodule

// File: rtl/nand_ci_seq.sv
module nand_ci_seq
   import nand_ci_pkg::*;
#(
   parameter int READ_CYC  = 20,
   parameter int PROG_CYC  = 40,
   parameter int ERASE_CYC = 60
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cmd_ev,
   input  logic [7:0] ev_byte,
   input  logic       wp_n,
   output logic       busy,
   output logic       addr_ok,
   output logic       in_pg,
   output logic       op_go,
   output op_kind_e   op_kind
);
   localparam int MAXC = (READ_CYC > PROG_CYC) ?
                         ((READ_CYC > ERASE_CYC) ? READ_CYC : ERASE_CYC) :
                         ((PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC);
   localparam int TW = $clog2(MAXC + 1);

   if (READ_CYC < 1 || PROG_CYC < 1 || ERASE_CYC < 1) begin : g_bad_cyc
      $error("operation durations must be at least one clock");
   end

   seq_e          st, nxt_st;
   logic          read_mode, nxt_rm;
   logic          cache_on, nxt_cache;
   logic          go;
   op_kind_e      kind;
   logic [TW-1:0] timer, tload;

   assign addr_ok = !busy && (st == S_RD_ADR || st == S_RDO_ADR ||
                              st == S_PG || st == S_ER_ADR);
   assign in_pg   = !busy && st == S_PG;

   always_comb begin
      nxt_st    = st;
      nxt_rm    = read_mode;
      nxt_cache = cache_on;
      go        = 1'b0;
      kind      = OP_NONE;
      if (cmd_ev && !busy) begin
         nxt_st = S_IDLE;
         case (ev_byte)
            C_READ: begin
               nxt_st = S_RD_ADR;
               nxt_rm = 1'b1;
            end
            C_READ_GO, C_CACHE_GO: begin
               if (st == S_RD_ADR || (st == S_IDLE && read_mode)) begin
                  go        = 1'b1;
                  kind      = OP_READ;
                  nxt_cache = (ev_byte == C_CACHE_GO);
               end
            end
            C_CACHE_END: nxt_cache = 1'b0;
            C_RDO:       nxt_st = cache_on ? S_IDLE : S_RDO_ADR;
            C_PROG: begin
               nxt_rm = 1'b0;
               nxt_st = wp_n ? S_PG : S_IDLE;
            end
            C_PROG_GO: begin
               if (st == S_PG && wp_n) begin
                  go   = 1'b1;
                  kind = OP_PROG;
               end
            end
            C_ERASE: begin
               nxt_rm = 1'b0;
               nxt_st = wp_n ? S_ER_ADR : S_IDLE;
            end
            C_ERASE_GO: begin
               if (st == S_ER_ADR && wp_n) begin
                  go   = 1'b1;
                  kind = OP_ERASE;
               end
            end
            default: nxt_st = S_IDLE;
         endcase
      end
   end

   always_comb begin
      case (kind)
         OP_PROG:  tload = TW'(PROG_CYC - 1);
         OP_ERASE: tload = TW'(ERASE_CYC - 1);
         default:  tload = TW'(READ_CYC - 1);
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st        <= S_IDLE;
         read_mode <= 1'b1;
         cache_on  <= 1'b0;
         busy      <= 1'b0;
         timer     <= '0;
         op_go     <= 1'b0;
         op_kind   <= OP_NONE;
      end else begin
         st        <= nxt_st;
         read_mode <= nxt_rm;
         cache_on  <= nxt_cache;
         op_go     <= go;
         if (go) begin
            busy    <= 1'b1;
            timer   <= tload;
            op_kind <= kind;
         end else if (busy) begin
            if (timer == '0)
               busy <= 1'b0;
            else
               timer <= timer - TW'(1);
         end
      end
   end

   // R9: no new operation starts while one is running
   a_r9_no_go_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
      busy && $past(busy) |-> !op_go);

   // R7: program and erase start only with write protect released
   a_r7_wp_gate: assert property (@(posedge clk) disable iff (!rst_n)
      op_go && (op_kind == OP_PROG || op_kind == OP_ERASE) |-> $past(wp_n));

   // R8: busy rises only together with a start pulse
   a_r8_busy_origin: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> op_go);
endmodule

// File: rtl/nand_cmd_if.sv
module nand_cmd_if
   import nand_ci_pkg::*;
#(
   parameter int MAIN_BYTES      = 2048,
   parameter int SPARE_BYTES     = 64,
   parameter int PAGES_PER_BLOCK = 64,
   parameter int BLOCK_COUNT     = 4096,
   parameter int READ_CYC        = 20,
   parameter int PROG_CYC        = 40,
   parameter int ERASE_CYC       = 60,
   localparam int PAGE_BYTES = MAIN_BYTES + SPARE_BYTES,
   localparam int COL_W      = $clog2(PAGE_BYTES),
   localparam int PAGE_W     = $clog2(PAGES_PER_BLOCK),
   localparam int BLK_W      = $clog2(BLOCK_COUNT)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_n,
   input  logic              cle,
   input  logic              ale,
   input  logic              re_n,
   input  logic              we_n,
   input  logic              wp_n,
   input  logic [7:0]        io_in,
   output logic              rb_n,
   output logic [COL_W-1:0]  col_ptr,
   output logic [PAGE_W-1:0] page_idx,
   output logic [BLK_W-1:0]  block_idx,
   output logic              din_we,
   output logic [7:0]        din_data,
   output logic              op_go,
   output logic [1:0]        op_kind
);
   localparam int LAST_COL = PAGE_BYTES - 1;

   logic       cmd_ev, adr_ev, dat_ev, re_ev;
   logic [7:0] ev_byte;
   logic       busy, addr_ok, in_pg, col_inc, take_dat;
   op_kind_e   kind_q;

   nand_ci_bus_sampler u_smp (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .cle(cle), .ale(ale),
      .re_n(re_n), .we_n(we_n), .io_in(io_in),
      .cmd_ev(cmd_ev), .adr_ev(adr_ev), .dat_ev(dat_ev), .re_ev(re_ev),
      .ev_byte(ev_byte)
   );

   nand_ci_seq #(
      .READ_CYC(READ_CYC), .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .cmd_ev(cmd_ev), .ev_byte(ev_byte),
      .wp_n(wp_n), .busy(busy), .addr_ok(addr_ok), .in_pg(in_pg),
      .op_go(op_go), .op_kind(kind_q)
   );

   assign take_dat = dat_ev && in_pg;
   assign col_inc  = take_dat || (re_ev && !busy);

   nand_ci_addr_asm #(
      .COL_W(COL_W), .PAGE_W(PAGE_W), .BLK_W(BLK_W), .LAST_COL(LAST_COL)
   ) u_adr (
      .clk(clk), .rst_n(rst_n), .cmd_ev(cmd_ev && !busy),
      .adr_ev(adr_ev && addr_ok), .col_inc(col_inc), .ev_byte(ev_byte),
      .col_ptr(col_ptr), .page_idx(page_idx), .block_idx(block_idx)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         din_we   <= 1'b0;
         din_data <= '0;
      end else begin
         din_we   <= take_dat;
         din_data <= ev_byte;
      end
   end

   assign rb_n    = !busy;
   assign op_kind = kind_q;

   // R3: every accepted data byte moves the pointer forward by one
   a_r3_din_step: assert property (@(posedge clk) disable iff (!rst_n)
      din_we && $past(col_ptr) != COL_W'(LAST_COL) |-> col_ptr == $past(col_ptr) + COL_W'(1));
endmodule

// File: tb/nand_cmd_if_tb_top.sv
`timescale 1ns/1ps
module nand_cmd_if_tb_top;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ce_n = 1'b0, cle = 1'b0, ale = 1'b0, re_n = 1'b1, we_n = 1'b1, wp_n = 1'b1;
   logic [7:0] io_in = '0;
   logic rb_n, din_we, op_go;
   logic [11:0] col_ptr, block_idx;
   logic [5:0] page_idx;
   logic [7:0] din_data;
   logic [1:0] op_kind;

   always #2 clk = ~clk;

   nand_cmd_if dut_i (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .cle(cle), .ale(ale), .re_n(re_n),
      .we_n(we_n), .wp_n(wp_n), .io_in(io_in), .rb_n(rb_n), .col_ptr(col_ptr),
      .page_idx(page_idx), .block_idx(block_idx), .din_we(din_we),
      .din_data(din_data), .op_go(op_go), .op_kind(op_kind)
   );

   typedef struct packed {
      logic [1:0]  kind;
      logic [5:0]  page;
      logic [11:0] blk;
   } op_t;

   op_t        exp_ops[$];
   logic [7:0] exp_din[$];
   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // monitor: pops the scoreboard whenever the design produces a result
   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (op_go) begin
            if (exp_ops.size() == 0) begin
               check("R10 unexpected op_go (R7/R9)", 32'(op_kind), 32'hFF);
            end else begin
               op_t e;
               e = exp_ops.pop_front();
               check("R5 op_kind", 32'(op_kind), 32'(e.kind));
               check("R2 page_idx", 32'(page_idx), 32'(e.page));
               check("R2 block_idx", 32'(block_idx), 32'(e.blk));
            end
         end
         if (din_we) begin
            if (exp_din.size() == 0)
               check("R3 unexpected din_we", 32'(din_data), 32'hFFF);
            else
               check("R3 din_data", 32'(din_data), 32'(exp_din.pop_front()));
         end
      end
   end

   task automatic bus_wr(input logic c, input logic a, input logic [7:0] v);
      @(negedge clk); cle = c; ale = a; io_in = v; we_n = 1'b0;
      @(negedge clk); we_n = 1'b1;
      @(negedge clk); cle = 1'b0; ale = 1'b0;
      @(negedge clk);
   endtask

   task automatic cmd(input logic [7:0] v);  bus_wr(1'b1, 1'b0, v); endtask
   task automatic adr(input logic [7:0] v);  bus_wr(1'b0, 1'b1, v); endtask
   task automatic dat(input logic [7:0] v);  bus_wr(1'b0, 1'b0, v); endtask

   task automatic re_pulse();
      @(negedge clk); re_n = 1'b0;
      @(negedge clk); re_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic addr5(input logic [11:0] col, input logic [5:0] pg, input logic [11:0] blk);
      logic [23:0] row;
      row = {6'd0, blk, pg};
      adr(col[7:0]);
      adr({4'h0, col[11:8]});
      adr(row[7:0]);
      adr(row[15:8]);
      adr(row[23:16]);
   endtask

   task automatic push_op(input logic [1:0] k, input logic [5:0] pg, input logic [11:0] blk);
      op_t e;
      e.kind = k; e.page = pg; e.blk = blk;
      exp_ops.push_back(e);
   endtask

   task automatic wait_ready();
      for (int i = 0; i < 200 && rb_n !== 1'b1; i++) @(negedge clk);
   endtask

   task automatic finish_run();
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog expired");
         finish_run();
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 rb_n", 32'(rb_n), 32'd1);
      check("R1 col_ptr", 32'(col_ptr), 32'd0);
      check("R1 op_go", 32'(op_go), 32'd0);
      check("R1 din_we", 32'(din_we), 32'd0);

      // R5/R8 plain read, busy exactly 20 clocks
      cmd(8'h00);
      addr5(12'h134, 6'd5, 12'h123);
      check("R2 column from two cycles", 32'(col_ptr), 32'h134);
      push_op(2'd1, 6'd5, 12'h123);
      cmd(8'h30);
      check("R8 busy after read confirm", 32'(rb_n), 32'd0);
      repeat (19) @(negedge clk);
      check("R8 read busy last clock", 32'(rb_n), 32'd0);
      @(negedge clk);
      check("R8 read busy released", 32'(rb_n), 32'd1);

      // R4 read strobe advances the pointer
      re_pulse(); re_pulse(); re_pulse();
      check("R4 pointer after three strobes", 32'(col_ptr), 32'h137);

      // R5 lone confirm repeats the read
      push_op(2'd1, 6'd5, 12'h123);
      cmd(8'h30);
      wait_ready();

      // R6 random output moves the pointer without an operation
      cmd(8'h05); adr(8'h20); adr(8'h00); cmd(8'hE0);
      check("R6 random output column", 32'(col_ptr), 32'h020);
      check("R6 no busy", 32'(rb_n), 32'd1);

      // R2 extra address cycles ignored
      cmd(8'h00);
      addr5(12'h001, 6'd9, 12'h0AB);
      adr(8'hFF); adr(8'hFF);
      check("R2 page after extra cycles", 32'(page_idx), 32'd9);
      check("R2 block after extra cycles", 32'(block_idx), 32'h0AB);
      push_op(2'd1, 6'd9, 12'h0AB);
      cmd(8'h30);
      wait_ready();

      // R3/R7 program with data
      cmd(8'h80);
      addr5(12'h010, 6'd63, 12'h007);
      exp_din.push_back(8'hAA); exp_din.push_back(8'hBB); exp_din.push_back(8'hCC);
      dat(8'hAA); dat(8'hBB); dat(8'hCC);
      check("R3 pointer after three bytes", 32'(col_ptr), 32'h013);
      push_op(2'd2, 6'd63, 12'h007);
      cmd(8'h10);
      check("R8 busy after program", 32'(rb_n), 32'd0);
      repeat (39) @(negedge clk);
      check("R8 program busy last clock", 32'(rb_n), 32'd0);
      @(negedge clk);
      check("R8 program busy released", 32'(rb_n), 32'd1);

      // R7 write protect at the opening code
      wp_n = 1'b0;
      cmd(8'h80); addr5(12'h000, 6'd1, 12'h001); dat(8'h11); cmd(8'h10);
      cmd(8'h60); adr(8'h00); adr(8'h01); adr(8'h00); cmd(8'hD0);
      check("R7 protected: stays ready", 32'(rb_n), 32'd1);
      // R7 write protect at the confirm
      wp_n = 1'b1;
      cmd(8'h60); adr(8'h40); adr(8'h00); adr(8'h00);
      wp_n = 1'b0;
      cmd(8'hD0);
      check("R7 protected confirm: stays ready", 32'(rb_n), 32'd1);
      wp_n = 1'b1;

      // R7 erase with three row cycles, R9 activity while busy ignored
      cmd(8'h60); adr(8'hC0); adr(8'hFF); adr(8'h03);
      push_op(2'd3, 6'd0, 12'hFFF);
      cmd(8'hD0);
      check("R8 busy after erase", 32'(rb_n), 32'd0);
      cmd(8'h05); adr(8'h77); adr(8'h00); cmd(8'hE0);
      re_pulse();
      cmd(8'h30);
      check("R9 pointer held while busy", 32'(col_ptr), 32'h013);
      wait_ready();
      check("R9 ready after erase", 32'(rb_n), 32'd1);

      // R6 cache read blocks random output until 34h
      cmd(8'h00);
      addr5(12'h005, 6'd1, 12'h002);
      push_op(2'd1, 6'd1, 12'h002);
      cmd(8'h31);
      wait_ready();
      cmd(8'h05); adr(8'h40); adr(8'h00); cmd(8'hE0);
      check("R6 refused during cache read", 32'(col_ptr), 32'h005);
      cmd(8'h34);
      cmd(8'h05); adr(8'h40); adr(8'h00); cmd(8'hE0);
      check("R6 accepted after cache end", 32'(col_ptr), 32'h040);

      // R10 unknown code drops pending program
      cmd(8'h80); addr5(12'h100, 6'd2, 12'h003);
      cmd(8'h77);
      dat(8'h55);
      cmd(8'h10);
      check("R10 no operation after unknown code", 32'(rb_n), 32'd1);
      check("R10 pointer unchanged", 32'(col_ptr), 32'h100);

      // R4 last column and clamp
      cmd(8'h05); adr(8'h3F); adr(8'h08); cmd(8'hE0);
      check("R4 last column loaded", 32'(col_ptr), 32'h83F);
      re_pulse();
      check("R4 pointer saturates", 32'(col_ptr), 32'h83F);
      cmd(8'h05); adr(8'hFF); adr(8'h0F); cmd(8'hE0);
      check("R4 out-of-page column clamped", 32'(col_ptr), 32'h83F);

      repeat (4) @(negedge clk);
      check("R5 scoreboard drained", 32'(exp_ops.size()), 32'd0);
      check("R3 data queue drained", 32'(exp_din.size()), 32'd0);
      finish_run();
   end
endmodule